// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a row of stages that can be filled all at once from a parallel data bus and then emptied one bit at a time through a serial output. It models a board-level shift register as a peripheral inside a synchronous design. One system clock runs the whole block. The external shift clock and clock-inhibit pins are treated as slow signals. They are synchronized and edge-detected internally, and are never used as clocks.

The active-low load control is level-sensitive. While it is low, the stages copy the parallel bus every system cycle, whatever the other pins do.

While the load control is high, the register shifts once for each rising edge of the OR of the shift clock and the clock-inhibit pin. Either pin can therefore act as the clock while the other is held low. On each shift, the bit on the serial input enters the first stage. Both the last stage and its complement drive output pins, so several blocks can be chained by wiring one block's serial output to the next block's serial input.

Top module: `par_serial_shifter`

## Requirements
- R1: An active-low synchronous reset clears every stage to 0, so serOut reads 0 and serOutN reads 1 after reset.
- R2: While shLoadN is low, the stages follow parIn every cycle. parIn bit 0 feeds the first stage and bit STAGES-1 feeds the output stage, and a change on parIn during the load shows up on serOut.
- R3: While shLoadN is low, activity on shiftClk, clkInhibit and serIn has no effect on the stages.
- R4: With shLoadN high and clkInhibit low, a rising edge on shiftClk shifts the register by one stage.
- R5: With shLoadN high and shiftClk low, a rising edge on clkInhibit shifts the register by one stage.
- R6: A rising edge on one pin while the other pin is already high produces no shift. A falling edge on either pin produces no shift.
- R7: On a shift, each stage takes the value of its neighbour on the input side and serIn enters stage 0. After a load, successive shifts present parIn bits STAGES-1 down to 0 on serOut, then the serial-input bits in the order they were shifted in.
- R8: serOutN is always the complement of serOut.
- R9: With shLoadN high and no rising edge on the OR of the two clock pins, the stages hold their value.
- R10: If a load and a detected shift edge arrive in the same system cycle, the load wins and no shift is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| shLoadN | input | 1 | Low: stages copy parIn; high: hold or shift |
| shiftClk | input | 1 | External shift clock pin, asynchronous |
| clkInhibit | input | 1 | Clock-inhibit pin, ORed with shiftClk, asynchronous |
| serIn | input | 1 | Serial data that enters stage 0 on a shift |
| parIn | input | STAGES | Parallel data; bit 0 is the far end, bit STAGES-1 the output end |
| serOut | output | 1 | Value of the last stage |
| serOutN | output | 1 | Complement of the last stage |

## Verification
The assertions assume four things about the inputs:
- Every pin level is held for several system cycles, so each level passes the two-flop synchronizer.
- parIn and serIn stay stable from a pin change until the delayed strobe has been applied, because these data inputs are sampled without synchronization.
- Reset is applied before any pin activity.
- The clock-inhibit pin rises only while shiftClk is already high whenever a non-shift is intended.

The stimulus respects these by driving inputs only at falling system edges, waiting five cycles after every pin change, and keeping serIn fixed for the whole of each shift sequence. Random operations (loads, shifts on either pin, the blocked inhibit rise, idle periods) are mixed with directed sequences: a full drain after a load, a load held during pin activity, and a shift edge that coincides with a load.

// File: rtl/par_serial_shifter_pkg.sv
package par_serial_shifter_pkg;

  // Strobes sent from the control path to the datapath each system cycle.
  typedef struct packed {
    logic load;   // load level is active (shLoadN sampled low)
    logic shift;  // rising edge detected on the OR of the clock pins
  } strobe_t;

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] firstFlop;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        firstFlop[i] <= RESET_VAL[i];
        syncOut[i]   <= RESET_VAL[i];
      end else begin
        firstFlop[i] <= asyncIn[i];
        syncOut[i]   <= firstFlop[i];
      end
    end
  end

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import par_serial_shifter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    shLoadN,
  input  logic    shiftClk,
  input  logic    clkInhibit,
  output strobe_t strobe
);

  localparam int PIN_COUNT = 3;
  localparam int IDX_LOAD  = 0;
  localparam int IDX_CLK   = 1;
  localparam int IDX_INH   = 2;

  logic [PIN_COUNT-1:0] pinRaw;
  logic [PIN_COUNT-1:0] pinSync;
  logic                 clockOr;
  logic                 clockOrPrev;

  assign pinRaw[IDX_LOAD] = shLoadN;
  assign pinRaw[IDX_CLK]  = shiftClk;
  assign pinRaw[IDX_INH]  = clkInhibit;

  // Reset value of all ones: not loading, and no false edge when the
  // pins sit high as reset is released.
  pss_sync #(
    .WIDTH    (PIN_COUNT),
    .RESET_VAL('1)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinRaw),
    .syncOut(pinSync)
  );

  assign clockOr = pinSync[IDX_CLK] | pinSync[IDX_INH];

  always_ff @(posedge clk) begin
    if (!rstN) clockOrPrev <= 1'b1;
    else       clockOrPrev <= clockOr;
  end

  always_comb begin
    strobe.load  = ~pinSync[IDX_LOAD];
    strobe.shift = clockOr & ~clockOrPrev;
  end

endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import par_serial_shifter_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              serIn,
  input  logic [STAGES-1:0] parIn,
  output logic [STAGES-1:0] stages
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] feedBit;

  // Each stage is fed by its neighbour on the input side; stage 0 by serIn.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign feedBit[i] = serIn;
    end else begin : g_body
      assign feedBit[i] = stages[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN)             stages[i] <= 1'b0;
      else if (strobe.load)  stages[i] <= parIn[i];
      else if (strobe.shift) stages[i] <= feedBit[i];
    end
  end

  logic unusedLast;
  assign unusedLast = stages[LAST];

endmodule

// File: rtl/par_serial_shifter.sv
module par_serial_shifter
  import par_serial_shifter_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shLoadN,
  input  logic              shiftClk,
  input  logic              clkInhibit,
  input  logic              serIn,
  input  logic [STAGES-1:0] parIn,
  output logic              serOut,
  output logic              serOutN
);

  strobe_t           strobe;
  logic [STAGES-1:0] stages;

  pss_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .shLoadN   (shLoadN),
    .shiftClk  (shiftClk),
    .clkInhibit(clkInhibit),
    .strobe    (strobe)
  );

  pss_datapath #(.STAGES(STAGES)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .serIn (serIn),
    .parIn (parIn),
    .stages(stages)
  );

  assign serOut  = stages[STAGES-1];
  assign serOutN = ~stages[STAGES-1];

endmodule

// File: rtl/par_serial_shifter_chk.sv
module par_serial_shifter_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              serIn,
  input logic [STAGES-1:0] parIn,
  input logic [STAGES-1:0] stages,
  input logic              loadNow,
  input logic              shiftNow
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (stages == '0)); // R1

  AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> (stages == $past(parIn))); // R2

  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && shiftNow) |=> (stages == $past(parIn))); // R10

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (shiftNow && !loadNow) |=>
      (stages == {$past(stages[STAGES-2:0]), $past(serIn)})); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftNow && !loadNow) |=> $stable(stages)); // R9

endmodule

bind par_serial_shifter par_serial_shifter_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .serIn   (serIn),
  .parIn   (parIn),
  .stages  (stages),
  .loadNow (strobe.load),
  .shiftNow(strobe.shift)
);

// File: tb/par_serial_shifter_test.sv
module par_serial_shifter_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int SETTLE     = 5;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         shLoadN;
  logic         shiftClk;
  logic         clkInhibit;
  logic         serIn;
  logic [N-1:0] parIn;
  logic         serOut;
  logic         serOutN;

  int           testsRun = 0;
  int           testsFailed = 0;
  logic [N-1:0] model;
  bit           finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_serial_shifter #(.STAGES(N)) uut (
    .clk(clk), .rstN(rstN), .shLoadN(shLoadN), .shiftClk(shiftClk),
    .clkInhibit(clkInhibit), .serIn(serIn), .parIn(parIn),
    .serOut(serOut), .serOutN(serOutN)
  );

  function automatic logic [N-1:0] shiftModel(logic [N-1:0] cur, logic bitIn);
    return {cur[N-2:0], bitIn};
  endfunction

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(string req);
    chk(req, serOut, model[N-1]);
    chk("R8", serOutN, ~model[N-1]);
  endtask

  task automatic doLoad(logic [N-1:0] data);
    shLoadN = 1'b0;
    parIn   = data;
    settle();
    model = data;
    checkOut("R2");
    shLoadN = 1'b1;
    settle();
    checkOut("R9");
  endtask

  // kind 0: shiftClk edge; 1: clkInhibit edge; 2: inhibit rises while clock high
  task automatic doShift(int kind, logic bitIn);
    serIn = bitIn;
    case (kind)
      0: begin
        shiftClk = 1'b1; settle();
        model = shiftModel(model, bitIn); checkOut("R4");
        shiftClk = 1'b0; settle(); checkOut("R6");
      end
      1: begin
        clkInhibit = 1'b1; settle();
        model = shiftModel(model, bitIn); checkOut("R5");
        clkInhibit = 1'b0; settle(); checkOut("R6");
      end
      default: begin
        shiftClk = 1'b1; settle();
        model = shiftModel(model, bitIn); checkOut("R4");
        clkInhibit = 1'b1; settle(); checkOut("R6");
        shiftClk = 1'b0; settle(); checkOut("R6");
        clkInhibit = 1'b0; settle(); checkOut("R6");
      end
    endcase
  endtask

  // Shift the whole register out; serOut must walk H..A then the fill bits.
  task automatic drain(logic [N-1:0] fill);
    for (int k = 0; k < N; k++) begin
      chk("R7", serOut, model[N-1]);
      doShift(k % 2, fill[k]);
    end
    for (int k = 0; k < N; k++) begin
      chk("R7", model[N-1-k], fill[k]);
    end
    chk("R7", serOut, fill[0]);
  endtask

  initial begin
    rstN = 1'b0; shLoadN = 1'b1; shiftClk = 1'b0; clkInhibit = 1'b0;
    serIn = 1'b1; parIn = '1;
    model = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkOut("R1");
    rstN = 1'b1;
    settle();
    checkOut("R1");

    // Load, then change parIn while load is held: stages follow (R2)
    shLoadN = 1'b0; parIn = 8'hA5; settle();
    model = 8'hA5; checkOut("R2");
    parIn = 8'h3C; settle();
    model = 8'h3C; checkOut("R2");
    parIn = 8'hC3; settle();
    model = 8'hC3; checkOut("R2");
    // Pin activity during load has no effect (R3)
    serIn = 1'b0; shiftClk = 1'b1; settle(); checkOut("R3");
    clkInhibit = 1'b1; settle(); checkOut("R3");
    shiftClk = 1'b0; clkInhibit = 1'b0; settle(); checkOut("R3");
    shLoadN = 1'b1; settle(); checkOut("R3");
    drain(8'b0110_1001);

    // Load and shift edge arriving together: load wins (R10)
    shLoadN = 1'b0; parIn = 8'h81; shiftClk = 1'b1; serIn = 1'b0;
    settle();
    model = 8'h81; checkOut("R10");
    shLoadN = 1'b1; settle(); checkOut("R10");
    shiftClk = 1'b0; settle(); checkOut("R10");
    drain(8'b1010_0101);

    // Blocked inhibit rise keeps contents (R6), directed pattern
    doLoad(8'b1000_0000);
    doShift(2, 1'b1);
    chk("R6", serOut, 1'b0);
    drain(8'hF0);

    // Random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: doLoad(N'($urandom));
        1: doShift(0, 1'($urandom));
        2: doShift(1, 1'($urandom));
        3: doShift(2, 1'($urandom));
        4: begin settle(); checkOut("R9"); end
        default: drain(N'($urandom));
      endcase
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule